// File: doc/BRIEF.md
# Shared RAM Ownership Arbiter

This block sits in front of a small set of local RAM blocks that a host CPU and a coprocessor share. Four requesters reach the RAM through it: the host CPU (data reads, data writes and instruction fetches), the coprocessor data port, the coprocessor instruction-fetch port, and a debug port. Two configuration bits per block decide who may use it. The ownership bit hands the block to the coprocessor. The role bit then makes a coprocessor block either a data block or a program block.

For a data block, host CPU and coprocessor accesses compete for the block. A fairness toggle makes sure neither side waits more than one extra cycle. For a program block, the coprocessor fetches its code, and the debugger may use only the cycles with no fetch to that block. Separate per-block protection bits can forbid host CPU writes and host CPU fetches. Ownership and role may only change while the coprocessor is idle. An attempt made while it is busy is dropped and recorded in a sticky flag.

Every port uses a one-cycle request/grant handshake. A request is granted, refused with an error, or stalled, all in the cycle it is raised. A granted read delivers its word on the following clock.

Top module: `shram_arbiter`

## Requirements
- R1: After reset, every block is owned by the host CPU with role bit 0, no protection is set, the violation flag is 0, every read-data output is 0, and the data-block tie-break of every block favours the coprocessor.
- R2: An address splits into a block index in its upper bits and a word index in its lower AW bits. Ownership bit b equal to 0 leaves block b with the host CPU. Coprocessor data and fetch requests to such a block get an error, while host CPU requests are granted.
- R3: When ownership bit b is 1 and role bit b is 0, block b is a data block and accepts both host CPU and coprocessor data requests. When both request it in the same cycle, the first such clash goes to the coprocessor and each later clash on that block goes to the side that lost the previous one, so a loser is served in the next cycle if it keeps requesting.
- R4: When ownership bit b is 1 and role bit b is 1, block b is a program block. Coprocessor fetches to it are granted, while host CPU and coprocessor data requests get an error. A debug request to it is granted only in a cycle with no fetch request to the same block, and otherwise stalls with neither grant nor error.
- R5: Protection bit b of the write-protect vector makes host CPU writes to block b end in an error. Protection bit b of the fetch-protect vector does the same for host CPU fetches (fetch high, write low). Host CPU plain reads stay allowed. Protection vectors can be written at any time.
- R6: An ownership/role write made while the coprocessor busy input is 1 leaves both vectors unchanged and sets the violation flag. The flag stays set until reset. The same write made while busy is 0 takes effect at the next clock.
- R7: An error is reported in the request cycle with no grant. A write refused with an error leaves memory unchanged, and a read refused or stalled returns 0 on the next clock.
- R8: A granted write stores its data at the next clock, and a granted read returns the stored word on the next clock.
- R9: On host-owned and data blocks, the debug port has the lowest priority. It is granted only when no legal host CPU or coprocessor data request targets the same block, and otherwise it stalls. Requests to different blocks are served in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cop_busy | input | 1 | Coprocessor has a task running |
| cfg_own_we | input | 1 | Write strobe for ownership and role vectors |
| cfg_msel_in | input | NBLK | New ownership vector (1 = coprocessor) |
| cfg_pgm_in | input | NBLK | New role vector (1 = program) |
| cfg_prot_we | input | 1 | Write strobe for protection vectors |
| cfg_wprot_in | input | NBLK | New host-write protection vector |
| cfg_fprot_in | input | NBLK | New host-fetch protection vector |
| cfg_msel | output | NBLK | Current ownership vector |
| cfg_pgm | output | NBLK | Current role vector |
| cfg_viol | output | 1 | Sticky configuration-violation flag |
| cpu_req | input | 1 | Host CPU request |
| cpu_we | input | 1 | Host CPU write |
| cpu_fetch | input | 1 | Host CPU read is an instruction fetch |
| cpu_addr | input | ADW | Host CPU address |
| cpu_wdata | input | DW | Host CPU write data |
| cpu_gnt | output | 1 | Host CPU grant |
| cpu_err | output | 1 | Host CPU error |
| cpu_rdata | output | DW | Host CPU read data |
| cop_req | input | 1 | Coprocessor data request |
| cop_we | input | 1 | Coprocessor data write |
| cop_addr | input | ADW | Coprocessor data address |
| cop_wdata | input | DW | Coprocessor write data |
| cop_gnt | output | 1 | Coprocessor data grant |
| cop_err | output | 1 | Coprocessor data error |
| cop_rdata | output | DW | Coprocessor read data |
| ife_req | input | 1 | Coprocessor fetch request |
| ife_addr | input | ADW | Coprocessor fetch address |
| ife_gnt | output | 1 | Fetch grant |
| ife_err | output | 1 | Fetch error |
| ife_rdata | output | DW | Fetched word |
| dbg_req | input | 1 | Debug request |
| dbg_we | input | 1 | Debug write |
| dbg_addr | input | ADW | Debug address |
| dbg_wdata | input | DW | Debug write data |
| dbg_gnt | output | 1 | Debug grant |
| dbg_rdata | output | DW | Debug read data |

## Verification
The bench builds the block with its default values: four blocks of sixteen 16-bit words. Four blocks are enough to hold a host block, a data block, a program block and a second host block at once. This lets one configuration exercise clashes on one block while other ports are served on other blocks in the same cycle. The small depth keeps the model memory in the bench trivial, and every word the bench reads back has a known value.

// File: rtl/shram_arbiter.sv
module shram_arbiter #(
  parameter int NBLK = 4,
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int ADW = BW + AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cop_busy,
  input  logic            cfg_own_we,
  input  logic [NBLK-1:0] cfg_msel_in,
  input  logic [NBLK-1:0] cfg_pgm_in,
  input  logic            cfg_prot_we,
  input  logic [NBLK-1:0] cfg_wprot_in,
  input  logic [NBLK-1:0] cfg_fprot_in,
  output logic [NBLK-1:0] cfg_msel,
  output logic [NBLK-1:0] cfg_pgm,
  output logic            cfg_viol,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic            cpu_fetch,
  input  logic [ADW-1:0]  cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic            cpu_gnt,
  output logic            cpu_err,
  output logic [DW-1:0]   cpu_rdata,
  input  logic            cop_req,
  input  logic            cop_we,
  input  logic [ADW-1:0]  cop_addr,
  input  logic [DW-1:0]   cop_wdata,
  output logic            cop_gnt,
  output logic            cop_err,
  output logic [DW-1:0]   cop_rdata,
  input  logic            ife_req,
  input  logic [ADW-1:0]  ife_addr,
  output logic            ife_gnt,
  output logic            ife_err,
  output logic [DW-1:0]   ife_rdata,
  input  logic            dbg_req,
  input  logic            dbg_we,
  input  logic [ADW-1:0]  dbg_addr,
  input  logic [DW-1:0]   dbg_wdata,
  output logic            dbg_gnt,
  output logic [DW-1:0]   dbg_rdata
);
  localparam int DEPTH = NBLK << AW;

  logic [DW-1:0]   mem [DEPTH];
  logic [NBLK-1:0] msel_q, pgm_q, wp_q, fp_q, pri_cop_q;
  logic            viol_q;
  logic [BW-1:0]   cb, kb, fb, db;
  logic            cpu_ok, cop_ok, ife_ok;
  logic            cpu_v, cop_v, ife_v, clash;

  assign cb = cpu_addr[ADW-1:AW];
  assign kb = cop_addr[ADW-1:AW];
  assign fb = ife_addr[ADW-1:AW];
  assign db = dbg_addr[ADW-1:AW];

  assign cpu_ok = !(msel_q[cb] && pgm_q[cb])
               && !(cpu_we && wp_q[cb])
               && !(!cpu_we && cpu_fetch && fp_q[cb]);
  assign cop_ok = msel_q[kb] && !pgm_q[kb];
  assign ife_ok = msel_q[fb] && pgm_q[fb];

  assign cpu_v = cpu_req && cpu_ok;
  assign cop_v = cop_req && cop_ok;
  assign ife_v = ife_req && ife_ok;
  assign clash = cpu_v && cop_v && (cb == kb);

  assign cpu_gnt = cpu_v && !(clash && pri_cop_q[cb]);
  assign cop_gnt = cop_v && !(clash && !pri_cop_q[kb]);
  assign ife_gnt = ife_v;
  assign dbg_gnt = dbg_req && !(cpu_v && cb == db)
                && !(cop_v && kb == db) && !(ife_v && fb == db);

  assign cpu_err = cpu_req && !cpu_ok;
  assign cop_err = cop_req && !cop_ok;
  assign ife_err = ife_req && !ife_ok;

  assign cfg_msel = msel_q;
  assign cfg_pgm  = pgm_q;
  assign cfg_viol = viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel_q    <= '0;
      pgm_q     <= '0;
      wp_q      <= '0;
      fp_q      <= '0;
      pri_cop_q <= '1;
      viol_q    <= 1'b0;
    end else begin
      if (cfg_own_we) begin
        if (cop_busy) viol_q <= 1'b1;
        else begin
          msel_q <= cfg_msel_in;
          pgm_q  <= cfg_pgm_in;
        end
      end
      if (cfg_prot_we) begin
        wp_q <= cfg_wprot_in;
        fp_q <= cfg_fprot_in;
      end
      if (clash) pri_cop_q[cb] <= ~pri_cop_q[cb];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      cop_rdata <= '0;
      ife_rdata <= '0;
      dbg_rdata <= '0;
    end else begin
      cpu_rdata <= (cpu_gnt && !cpu_we) ? mem[cpu_addr] : '0;
      cop_rdata <= (cop_gnt && !cop_we) ? mem[cop_addr] : '0;
      ife_rdata <= ife_gnt ? mem[ife_addr] : '0;
      dbg_rdata <= (dbg_gnt && !dbg_we) ? mem[dbg_addr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_gnt && cpu_we) mem[cpu_addr] <= cpu_wdata;
    if (cop_gnt && cop_we) mem[cop_addr] <= cop_wdata;
    if (dbg_gnt && dbg_we) mem[dbg_addr] <= dbg_wdata;
  end
endmodule

// File: rtl/shram_arbiter_chk.sv
module shram_arbiter_chk #(
  parameter int NBLK = 4,
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int ADW = BW + AW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cop_busy,
  input logic [NBLK-1:0] cfg_msel,
  input logic [NBLK-1:0] cfg_pgm,
  input logic            cfg_viol,
  input logic            cpu_req,
  input logic [ADW-1:0]  cpu_addr,
  input logic            cpu_gnt,
  input logic            cpu_err,
  input logic [DW-1:0]   cpu_rdata,
  input logic            cop_req,
  input logic [ADW-1:0]  cop_addr,
  input logic            cop_gnt,
  input logic            cop_err,
  input logic [DW-1:0]   cop_rdata,
  input logic            ife_req,
  input logic [ADW-1:0]  ife_addr,
  input logic            ife_err,
  input logic [ADW-1:0]  dbg_addr,
  input logic            dbg_gnt
);
  a_r3_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && cop_gnt) |-> (cpu_addr[ADW-1:AW] != cop_addr[ADW-1:AW]));

  a_r3_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_gnt && !cpu_err) |=>
      !(cpu_req && !cpu_err && $stable(cpu_addr) && !cpu_gnt));

  a_r4_dbg_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_gnt && ife_req && !ife_err) |-> (ife_addr[ADW-1:AW] != dbg_addr[ADW-1:AW]));

  a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cop_busy |=> ($stable(cfg_msel) && $stable(cfg_pgm)));

  a_r6_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_viol |=> cfg_viol);

  a_r7_cpu_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_err) |=> (cpu_rdata == '0));

  a_r7_cop_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_req && cop_err) |=> (cop_rdata == '0));
endmodule

bind shram_arbiter shram_arbiter_chk #(.NBLK(NBLK), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cop_busy(cop_busy),
  .cfg_msel(cfg_msel), .cfg_pgm(cfg_pgm), .cfg_viol(cfg_viol),
  .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_gnt(cpu_gnt),
  .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
  .cop_req(cop_req), .cop_addr(cop_addr), .cop_gnt(cop_gnt),
  .cop_err(cop_err), .cop_rdata(cop_rdata),
  .ife_req(ife_req), .ife_addr(ife_addr), .ife_err(ife_err),
  .dbg_addr(dbg_addr), .dbg_gnt(dbg_gnt)
);

// File: tb/shram_arbiter_tb_top.sv
`timescale 1ns/100ps
module shram_arbiter_tb_top;
  localparam int NBLK = 4, AW = 4, DW = 16, ADW = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cop_busy, cfg_own_we, cfg_prot_we;
  logic [NBLK-1:0] cfg_msel_in, cfg_pgm_in, cfg_wprot_in, cfg_fprot_in;
  logic [NBLK-1:0] cfg_msel, cfg_pgm;
  logic cfg_viol;
  logic cpu_req, cpu_we, cpu_fetch, cpu_gnt, cpu_err;
  logic [ADW-1:0] cpu_addr, cop_addr, ife_addr, dbg_addr;
  logic [DW-1:0] cpu_wdata, cop_wdata, dbg_wdata;
  logic [DW-1:0] cpu_rdata, cop_rdata, ife_rdata, dbg_rdata;
  logic cop_req, cop_we, cop_gnt, cop_err;
  logic ife_req, ife_gnt, ife_err;
  logic dbg_req, dbg_we, dbg_gnt;

  shram_arbiter #(.NBLK(NBLK), .AW(AW), .DW(DW)) dut_i (.*);

  typedef struct { int due; int port; logic [DW-1:0] val; string req; } exp_t;
  exp_t q[$];
  logic [DW-1:0] mdl [64];
  int cyc = 0, nvec = 0, nbad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  always @(negedge clk) begin : mon
    exp_t e;
    logic [DW-1:0] got;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      case (e.port)
        0: got = cpu_rdata;
        1: got = cop_rdata;
        2: got = ife_rdata;
        default: got = dbg_rdata;
      endcase
      chk({e.req, " rdata"}, 32'(got), 32'(e.val));
    end
  end

  task automatic clr();
    cop_busy = 0; cfg_own_we = 0; cfg_prot_we = 0;
    cpu_req = 0; cpu_we = 0; cpu_fetch = 0; cpu_addr = '0; cpu_wdata = '0;
    cop_req = 0; cop_we = 0; cop_addr = '0; cop_wdata = '0;
    ife_req = 0; ife_addr = '0;
    dbg_req = 0; dbg_we = 0; dbg_addr = '0; dbg_wdata = '0;
  endtask

  task automatic drive(int p, bit we, bit fe, int a, int wd);
    case (p)
      0: begin cpu_req = 1; cpu_we = we; cpu_fetch = fe; cpu_addr = ADW'(a); cpu_wdata = DW'(wd); end
      1: begin cop_req = 1; cop_we = we; cop_addr = ADW'(a); cop_wdata = DW'(wd); end
      2: begin ife_req = 1; ife_addr = ADW'(a); end
      default: begin dbg_req = 1; dbg_we = we; dbg_addr = ADW'(a); dbg_wdata = DW'(wd); end
    endcase
  endtask

  task automatic expect_port(int p, bit we, int a, int wd, bit eg, bit ee, string r);
    exp_t e;
    logic g, er;
    case (p)
      0: begin g = cpu_gnt; er = cpu_err; end
      1: begin g = cop_gnt; er = cop_err; end
      2: begin g = ife_gnt; er = ife_err; end
      default: begin g = dbg_gnt; er = 1'b0; end
    endcase
    chk({r, " gnt"}, 32'(g), 32'(eg));
    chk({r, " err"}, 32'(er), 32'(ee));
    if (!we) begin
      e.due = cyc + 1; e.port = p; e.req = r;
      e.val = (eg && !ee) ? mdl[a] : '0;
      q.push_back(e);
    end else if (eg && !ee) mdl[a] = DW'(wd);
  endtask

  task automatic go(int p, bit we, bit fe, int a, int wd, bit eg, bit ee, string r);
    clr();
    drive(p, we, fe, a, wd);
    #1;
    expect_port(p, we, a, wd, eg, ee, r);
    @(negedge clk);
  endtask

  task automatic cfg_own(logic [3:0] ms, logic [3:0] pg, bit busy);
    clr();
    cop_busy = busy; cfg_own_we = 1; cfg_msel_in = ms; cfg_pgm_in = pg;
    @(negedge clk);
    clr();
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : drv
    rst_n = 0;
    cfg_msel_in = '0; cfg_pgm_in = '0; cfg_wprot_in = '0; cfg_fprot_in = '0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 msel", 32'(cfg_msel), 0);
    chk("R1 pgm", 32'(cfg_pgm), 0);
    chk("R1 viol", 32'(cfg_viol), 0);
    chk("R1 cpu_rdata", 32'(cpu_rdata), 0);
    chk("R1 ife_rdata", 32'(ife_rdata), 0);
    @(negedge clk);

    // R8: fill words in every block while all are host-owned
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 4; w++)
        go(0, 1, 0, b*16 + w, 16'h1000 + b*16 + w, 1, 0, "R8 cpu write");
    go(0, 0, 0, 2, 0, 1, 0, "R8 cpu read");
    go(0, 0, 1, 35, 0, 1, 0, "R8 cpu fetch");

    // R2 / R7: host-owned blocks refuse coprocessor ports
    go(1, 0, 0, 17, 0, 0, 1, "R2 cop read host block");
    go(2, 0, 0, 33, 0, 0, 1, "R2 fetch host block");
    go(1, 1, 0, 1, 16'hDEAD, 0, 1, "R7 cop write refused");
    go(0, 0, 0, 1, 0, 1, 0, "R7 memory unchanged");

    // R6: locked while busy, applied when idle
    cfg_own(4'b0110, 4'b0100, 1);
    #1;
    chk("R6 msel unchanged", 32'(cfg_msel), 0);
    chk("R6 pgm unchanged", 32'(cfg_pgm), 0);
    chk("R6 viol set", 32'(cfg_viol), 1);
    go(1, 0, 0, 17, 0, 0, 1, "R6 cop still refused");
    cfg_own(4'b0110, 4'b0100, 0);
    #1;
    chk("R6 msel applied", 32'(cfg_msel), 32'h6);
    chk("R6 pgm applied", 32'(cfg_pgm), 32'h4);
    chk("R6 viol sticky", 32'(cfg_viol), 1);
    @(negedge clk);

    // R3: data block 1
    go(1, 0, 0, 16, 0, 1, 0, "R3 cop read data block");
    go(1, 1, 0, 20, 16'hC0DE, 1, 0, "R3 cop write data block");
    go(0, 0, 0, 20, 0, 1, 0, "R3 cpu reads cop word");
    go(2, 0, 0, 17, 0, 0, 1, "R3 fetch data block refused");
    for (int k = 0; k < 3; k++) begin
      clr();
      drive(0, 0, 0, 18, 0);
      drive(1, 0, 0, 19, 0);
      #1;
      expect_port(0, 0, 18, 0, (k == 1), 0, "R3 clash cpu");
      expect_port(1, 0, 19, 0, (k != 1), 0, "R3 clash cop");
      @(negedge clk);
    end
    clr();
    drive(0, 1, 0, 3, 16'h0A0A);
    drive(1, 1, 0, 21, 16'h0B0B);
    #1;
    expect_port(0, 1, 3, 16'h0A0A, 1, 0, "R9 parallel cpu");
    expect_port(1, 1, 21, 16'h0B0B, 1, 0, "R9 parallel cop");
    @(negedge clk);
    go(1, 0, 0, 21, 0, 1, 0, "R8 cop readback");
    go(0, 0, 0, 3, 0, 1, 0, "R8 cpu readback");

    // R4: program block 2
    go(2, 0, 0, 33, 0, 1, 0, "R4 fetch program");
    go(0, 0, 0, 33, 0, 0, 1, "R4 cpu refused");
    go(0, 1, 0, 33, 16'hBAD0, 0, 1, "R4 cpu write refused");
    go(1, 0, 0, 34, 0, 0, 1, "R4 cop data refused");
    go(3, 1, 0, 34, 16'h5A5A, 1, 0, "R4 dbg write free cycle");
    go(2, 0, 0, 34, 0, 1, 0, "R4 fetch dbg word");
    go(2, 0, 0, 33, 0, 1, 0, "R7 refused write left word");
    clr();
    drive(2, 0, 0, 32, 0);
    drive(3, 0, 0, 34, 0);
    #1;
    expect_port(2, 0, 32, 0, 1, 0, "R4 fetch beats dbg");
    expect_port(3, 0, 34, 0, 0, 0, "R4 dbg stalls");
    @(negedge clk);
    clr();
    drive(2, 0, 0, 32, 0);
    drive(3, 0, 0, 1, 0);
    #1;
    expect_port(2, 0, 32, 0, 1, 0, "R4 fetch other block");
    expect_port(3, 0, 1, 0, 1, 0, "R4 dbg other block");
    @(negedge clk);

    // R9: debug lowest priority on host / data blocks
    clr();
    drive(0, 0, 0, 0, 0);
    drive(3, 1, 0, 0, 16'hFFFF);
    #1;
    expect_port(0, 0, 0, 0, 1, 0, "R9 cpu over dbg");
    expect_port(3, 1, 0, 16'hFFFF, 0, 0, "R9 dbg stalls");
    @(negedge clk);
    clr();
    drive(1, 0, 0, 16, 0);
    drive(3, 0, 0, 17, 0);
    #1;
    expect_port(1, 0, 16, 0, 1, 0, "R9 cop over dbg");
    expect_port(3, 0, 17, 0, 0, 0, "R9 dbg stalls data");
    @(negedge clk);
    go(0, 0, 0, 0, 0, 1, 0, "R9 stalled write dropped");
    go(3, 0, 0, 49, 0, 1, 0, "R9 dbg alone");

    // R5: protection
    clr();
    cfg_prot_we = 1; cfg_wprot_in = 4'b1000; cfg_fprot_in = 4'b0001;
    @(negedge clk);
    go(0, 1, 0, 48, 16'h7777, 0, 1, "R5 write protected");
    go(0, 0, 0, 48, 0, 1, 0, "R5 read allowed unchanged");
    go(0, 0, 1, 48, 0, 1, 0, "R5 fetch unprotected block");
    go(0, 0, 1, 2, 0, 0, 1, "R5 fetch protected");
    go(0, 0, 0, 2, 0, 1, 0, "R5 plain read allowed");
    go(0, 1, 0, 2, 16'h1234, 1, 0, "R5 write unprotected");
    go(0, 0, 0, 2, 0, 1, 0, "R5 readback");

    clr();
    repeat (3) @(negedge clk);
    chk("R7 queue drained", 32'(q.size()), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule